// File: doc/BRIEF.md
# Banked Interrupt Status Controller

This block gathers a wide vector of event inputs into banks of 32 sources each. Source number `i` belongs to bank `i / 32` at bit `i % 32`. A rising edge on a source latches a status bit, and the bit stays set until software clears it. Each bank has an enable word. The block raises a single registered interrupt line while any bank has a status bit that is set and also enabled.

Software reaches the banks through a plain word-addressed register port. The port has an address, a write strobe, write data and combinational read data. Each bank takes four word slots. The lower two address bits pick the register, and the bits above them pick the bank. Status reads always return the raw latched events, whether or not those sources are enabled. A static present mask, with one bit per bank, removes whole banks: a missing bank holds no state, reads as zero and never contributes to the interrupt line.

Top module: `irq_bank_ctrl`

## Requirements
- R1: After reset, every status word and every enable word reads zero, and `irq_o` is low.
- R2: A 0-to-1 change on a source sets its status bit on the next clock edge. The bit stays set while the source stays high, and a source held high does not set the bit again after a clear.
- R3: A status read returns the latched bits of the bank whether or not those bits are enabled.
- R4: A write to the clear slot (register select 0) clears exactly the status bits that are 1 in the write data and leaves the other bits alone. All ones empties the bank. The clear slot reads as zero.
- R5: If a rising edge and a clear hit the same bit in the same cycle, the bit ends up set.
- R6: A write to the enable slot (register select 1) replaces the whole 32-bit enable word, and the enable slot reads the word back. Writing zero disables the whole bank.
- R7: `irq_o` is a register. One cycle after any edge, it equals the OR, across present banks, of the status word ANDed with the enable word as they stood at that edge.
- R8: A bank whose bit in `BANK_PRESENT` is 0 reads zero in every slot, ignores writes and never sets `irq_o`, whatever its sources do.
- R9: Register select 3, and any bank index at or above `NUM_BANKS`, read zero and ignore writes.
- R10: The word address is `bank*4 + select`, with select 2 as the status slot. Source `i` appears in bank `i/32` at bit `i%32`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_BANKS*32 | Event inputs, source i at bit i |
| addr_i | input | ADDR_W | Word address {bank, select} |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for addr_i |
| irq_o | output | 1 | Registered combined interrupt |

## Verification
Directed sequences try a single source edge that is latched but disabled, a clear while the source stays high, a rising edge that coincides with its own clear, and an all-ones clear after several edges in one bank. Between them, these cases separate edge latching from level latching and separate a clear-wins policy from a set-wins policy. A missing bank and the reserved slots are written and then read back, which shows whether any state leaks into them. A long random phase then mixes sparse source toggles with writes to every slot, including absent banks and out-of-range banks. On every cycle it compares the read port and the interrupt line with a bench model, which catches wrong masking, slot swaps and an interrupt timed one cycle early or late.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

    localparam int SRC_PER_BANK = 32;
    localparam int SEL_W        = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_CLEAR  = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_RSVD   = 2'd3
    } reg_sel_e;

    typedef logic [SRC_PER_BANK-1:0] bank_word_t;

    typedef struct packed {
        bank_word_t status;
        bank_word_t enable;
        bank_word_t rise;
    } bank_view_t;

    typedef struct packed {
        logic clr_we;
        logic en_we;
    } bank_wr_t;

    // New status word: clear the masked bits, then OR in the edges (set wins).
    function automatic bank_word_t next_status(bank_word_t cur, bank_word_t clr, bank_word_t set);
        return (cur & ~clr) | set;
    endfunction

endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sig_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] sig_q;

    always_ff @(posedge clk) begin
        if (rst) sig_q <= '0;
        else     sig_q <= sig_i;
    end

    assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/irq_bank_slice.sv
module irq_bank_slice
    import irq_bank_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bank_word_t src_i,
    input  bank_wr_t   wr_i,
    input  bank_word_t wdata_i,
    output bank_view_t view_o
);
    bank_word_t rise;
    bank_word_t status_q;
    bank_word_t enable_q;
    bank_word_t clr_mask;

    irq_edge_detect #(.W(SRC_PER_BANK)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .sig_i  (src_i),
        .rise_o (rise)
    );

    assign clr_mask = wr_i.clr_we ? wdata_i : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            enable_q <= '0;
        end else begin
            status_q <= next_status(status_q, clr_mask, rise);
            if (wr_i.en_we) enable_q <= wdata_i;
        end
    end

    assign view_o.status = status_q;
    assign view_o.enable = enable_q;
    assign view_o.rise   = rise;
endmodule

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
    import irq_bank_pkg::*;
#(
    parameter int                   NUM_BANKS    = 4,
    parameter int                   ADDR_W       = 8,
    parameter logic [NUM_BANKS-1:0] BANK_PRESENT = '1
) (
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 we_i,
    output logic [NUM_BANKS-1:0] hit_o,
    output reg_sel_e             sel_o,
    output bank_wr_t             wr_o [NUM_BANKS]
);
    localparam int BIDX_W = ADDR_W - SEL_W;

    logic [BIDX_W-1:0] bidx;

    assign sel_o = reg_sel_e'(addr_i[SEL_W-1:0]);
    assign bidx  = addr_i[ADDR_W-1:SEL_W];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_dec
        assign hit_o[b]       = BANK_PRESENT[b] && (bidx == BIDX_W'(b));
        assign wr_o[b].clr_we = we_i && hit_o[b] && (sel_o == SEL_CLEAR);
        assign wr_o[b].en_we  = we_i && hit_o[b] && (sel_o == SEL_ENABLE);
    end
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
    import irq_bank_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic [NUM_BANKS-1:0] hit_i,
    input  reg_sel_e             sel_i,
    input  bank_view_t           view_i [NUM_BANKS],
    output bank_word_t           rdata_o
);
    always_comb begin
        rdata_o = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (hit_i[b]) begin
                unique case (sel_i)
                    SEL_ENABLE: rdata_o = rdata_o | view_i[b].enable;
                    SEL_STATUS: rdata_o = rdata_o | view_i[b].status;
                    default:    rdata_o = rdata_o;
                endcase
            end
        end
    end
endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
    import irq_bank_pkg::*;
#(
    parameter int                   NUM_BANKS    = 4,
    parameter int                   ADDR_W       = 8,
    parameter logic [NUM_BANKS-1:0] BANK_PRESENT = '1,
    localparam int                  NUM_SRC      = NUM_BANKS * SRC_PER_BANK
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               we_i,
    input  logic [31:0]        wdata_i,
    output logic [31:0]        rdata_o,
    output logic               irq_o
);
    logic [NUM_BANKS-1:0] hit;
    reg_sel_e             sel;
    bank_wr_t             wr   [NUM_BANKS];
    bank_view_t           view [NUM_BANKS];
    logic [NUM_BANKS-1:0] bank_pend;

    logic [NUM_SRC-1:0] status_all;
    logic [NUM_SRC-1:0] enable_all;
    logic [NUM_SRC-1:0] rise_all;

    irq_addr_decode #(
        .NUM_BANKS    (NUM_BANKS),
        .ADDR_W       (ADDR_W),
        .BANK_PRESENT (BANK_PRESENT)
    ) u_dec (
        .addr_i (addr_i),
        .we_i   (we_i),
        .hit_o  (hit),
        .sel_o  (sel),
        .wr_o   (wr)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        if (BANK_PRESENT[b]) begin : g_live
            irq_bank_slice u_slice (
                .clk     (clk),
                .rst     (rst),
                .src_i   (src_i[b*SRC_PER_BANK +: SRC_PER_BANK]),
                .wr_i    (wr[b]),
                .wdata_i (wdata_i),
                .view_o  (view[b])
            );
        end else begin : g_absent
            logic absent_unused;
            assign absent_unused = ^{src_i[b*SRC_PER_BANK +: SRC_PER_BANK], wr[b].clr_we, wr[b].en_we};
            assign view[b] = '0;
        end
        assign bank_pend[b] = |(view[b].status & view[b].enable);
        assign status_all[b*SRC_PER_BANK +: SRC_PER_BANK] = view[b].status;
        assign enable_all[b*SRC_PER_BANK +: SRC_PER_BANK] = view[b].enable;
        assign rise_all[b*SRC_PER_BANK +: SRC_PER_BANK]   = view[b].rise;
    end

    irq_read_mux #(.NUM_BANKS(NUM_BANKS)) u_rd (
        .hit_i   (hit),
        .sel_i   (sel),
        .view_i  (view),
        .rdata_o (rdata_o)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_o <= 1'b0;
        else     irq_o <= |bank_pend;
    end
endmodule

// File: rtl/irq_bank_ctrl_checker.sv
module irq_bank_ctrl_checker #(
    parameter int                   NUM_BANKS    = 4,
    parameter int                   ADDR_W       = 8,
    parameter logic [NUM_BANKS-1:0] BANK_PRESENT = '1,
    localparam int                  NUM_SRC      = NUM_BANKS * 32
) (
    input logic               clk,
    input logic               rst,
    input logic [ADDR_W-1:0]  addr_i,
    input logic [31:0]        rdata_o,
    input logic               irq_o,
    input logic [NUM_SRC-1:0] status_all,
    input logic [NUM_SRC-1:0] enable_all,
    input logic [NUM_SRC-1:0] rise_all
);
    logic [NUM_SRC-1:0] pmask;
    logic               addr_absent;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_pm
        assign pmask[b*32 +: 32] = {32{BANK_PRESENT[b]}};
    end

    always_comb begin
        addr_absent = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (!BANK_PRESENT[b] && (addr_i[ADDR_W-1:2] == (ADDR_W-2)'(b))) addr_absent = 1'b1;
        end
    end

    AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_o == $past(|(status_all & enable_all & pmask)))); // R7

    AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_all & $past(rise_all & pmask)) == $past(rise_all & pmask))); // R5

    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status_all & ~$past(status_all | rise_all)) == '0)); // R4

    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (addr_i[1:0] == 2'd3) |-> (rdata_o == 32'd0)); // R9

    AST_ABSENT_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        addr_absent |-> (rdata_o == 32'd0)); // R8
endmodule

bind irq_bank_ctrl irq_bank_ctrl_checker #(
    .NUM_BANKS    (NUM_BANKS),
    .ADDR_W       (ADDR_W),
    .BANK_PRESENT (BANK_PRESENT)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .addr_i     (addr_i),
    .rdata_o    (rdata_o),
    .irq_o      (irq_o),
    .status_all (status_all),
    .enable_all (enable_all),
    .rise_all   (rise_all)
);

// File: tb/test_irq_bank_ctrl.sv
module test_irq_bank_ctrl;
    localparam int             NB      = 4;
    localparam int             AW      = 8;
    localparam logic [NB-1:0]  PRESENT = 4'b1011;
    localparam int             NSRC    = NB * 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NSRC-1:0] src_i = '0;
    logic [AW-1:0]   addr_i = '0;
    logic            we_i = 1'b0;
    logic [31:0]     wdata_i = '0;
    logic [31:0]     rdata_o;
    logic            irq_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [31:0]     m_stat [NB];
    logic [31:0]     m_en   [NB];
    logic [NSRC-1:0] m_prev;
    logic            m_irq;

    always #5 clk = ~clk;

    irq_bank_ctrl #(.NUM_BANKS(NB), .ADDR_W(AW), .BANK_PRESENT(PRESENT)) i_irq_bank_ctrl (
        .clk(clk), .rst(rst), .src_i(src_i), .addr_i(addr_i), .we_i(we_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int b = 0; b < NB; b++) begin m_stat[b] = '0; m_en[b] = '0; end
        m_prev = '0;
        m_irq  = 1'b0;
    endtask

    function automatic logic [31:0] model_read(input logic [AW-1:0] a);
        int bk = int'(a[AW-1:2]);
        if (bk >= NB || !PRESENT[bk]) return 32'd0;
        if (a[1:0] == 2'd1) return m_en[bk];
        if (a[1:0] == 2'd2) return m_stat[bk];
        return 32'd0;
    endfunction

    task automatic model_update();
        logic nirq = 1'b0;
        int   wb   = int'(addr_i[AW-1:2]);
        for (int b = 0; b < NB; b++)
            if (PRESENT[b]) nirq = nirq | (|(m_stat[b] & m_en[b]));
        for (int b = 0; b < NB; b++) begin
            if (PRESENT[b]) begin
                logic [31:0] clr = (we_i && wb == b && addr_i[1:0] == 2'd0) ? wdata_i : 32'd0;
                logic [31:0] rs  = src_i[b*32 +: 32] & ~m_prev[b*32 +: 32];
                m_stat[b] = (m_stat[b] & ~clr) | rs;
                if (we_i && wb == b && addr_i[1:0] == 2'd1) m_en[b] = wdata_i;
            end
        end
        m_prev = src_i;
        m_irq  = nirq;
    endtask

    // One clock: model follows the edge, inputs return to idle at the falling edge.
    task automatic step();
        @(posedge clk);
        if (rst) model_reset(); else model_update();
        @(negedge clk);
        we_i = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input string tag, input logic [31:0] exp);
        addr_i = a;
        #1;
        chk(tag, rdata_o, exp);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        addr_i = a; wdata_i = d; we_i = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) step();
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        rd(8'd6, "R1 status bank1", 32'd0);
        rd(8'd1, "R1 enable bank0", 32'd0);
        chk("R1 irq", {31'd0, irq_o}, 32'd0);

        // R2/R10: source 37 -> bank 1 bit 5; R3: visible while disabled
        src_i[37] = 1'b1;
        step();
        rd(8'd6, "R10 R2 bank1 status", 32'h20);
        step();
        rd(8'd6, "R3 raw status disabled", 32'h20);
        chk("R3 irq stays low", {31'd0, irq_o}, 32'd0);

        // R4/R2: clear while source held high, no retrigger
        wr(8'd4, 32'h20);
        step();
        step();
        rd(8'd6, "R2 R4 no retrigger", 32'd0);
        rd(8'd4, "R4 clear slot reads zero", 32'd0);

        // R5: edge and clear on same bit in same cycle
        src_i[37] = 1'b0;
        step();
        src_i[37] = 1'b1;
        wr(8'd4, 32'h20);
        step();
        rd(8'd6, "R5 set wins", 32'h20);

        // R6/R7: enable, readback, registered irq
        wr(8'd5, 32'h20);
        step();
        rd(8'd5, "R6 enable readback", 32'h20);
        chk("R7 irq not yet", {31'd0, irq_o}, 32'd0);
        step();
        chk("R7 irq raised", {31'd0, irq_o}, 32'd1);
        wr(8'd5, 32'd0);
        step();
        step();
        chk("R6 R7 zero enable drops irq", {31'd0, irq_o}, 32'd0);
        wr(8'd4, 32'hFFFF_FFFF);
        step();

        // R8: absent bank 2
        wr(8'd9, 32'hFFFF_FFFF);
        step();
        rd(8'd9, "R8 absent enable", 32'd0);
        src_i[64] = 1'b1;
        step();
        step();
        rd(8'd10, "R8 absent status", 32'd0);
        chk("R8 absent irq", {31'd0, irq_o}, 32'd0);

        // R9: reserved slot and out-of-range bank
        wr(8'd7, 32'hFFFF_FFFF);
        step();
        rd(8'd7, "R9 reserved slot", 32'd0);
        rd(8'd5, "R9 enable untouched", 32'd0);
        wr(8'd21, 32'hFFFF_FFFF);
        step();
        rd(8'd21, "R9 out-of-range bank", 32'd0);

        // R4: full clear after several edges
        src_i[3:0] = 4'hF;
        step();
        rd(8'd2, "R2 bank0 multi edge", 32'hF);
        wr(8'd0, 32'hFFFF_FFFF);
        step();
        rd(8'd2, "R4 all-ones clear", 32'd0);

        // Random phase against the model: R7 irq, R3/R6/R4 reads
        for (int n = 0; n < 4000; n++) begin
            src_i = src_i ^ ({$urandom, $urandom, $urandom, $urandom}
                           & {$urandom, $urandom, $urandom, $urandom}
                           & {$urandom, $urandom, $urandom, $urandom});
            addr_i = AW'({$urandom_range(5), 2'(($urandom & 3))});
            we_i   = ($urandom_range(3) == 0);
            wdata_i = ($urandom_range(7) == 0) ? 32'hFFFF_FFFF : $urandom;
            #1;
            chk("R7 random irq", {31'd0, irq_o}, {31'd0, m_irq});
            chk("R3 R6 random read", rdata_o, model_read(addr_i));
            step();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule